// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds ten 48-bit event counters for one CPU core. Software programs them through a single-cycle register port. Counter 0 counts clock cycles and counter 1 counts retired instructions. Counters 2 to 9 each pick one line of a 256-wide event pulse vector through an 8-bit selector. The selectors are packed four to a register: counters 2..5 share one select register and counters 6..9 share the other.

Each counter has these controls of its own:
- an enable bit;
- an interrupt-enable bit;
- a user-mode qualifier and a kernel-mode qualifier, checked against the current privilege level.

When an increment carries a counter's bit 47 from 0 to 1, the counter's overflow status bit is set. The interrupt line rises when the global delivery mode is "fast" and any counter has both its overflow bit and its interrupt enable set. An interrupt-active flag records that the line was raised. Any write to the control register clears this flag, which lets software dismiss a spurious interrupt.

Register map, with 5-bit addresses and 48-bit data:
- 0x00..0x09: the counters.
- 0x10: control.
- 0x11: privilege qualifiers.
- 0x12: select register for counters 2..5.
- 0x13: select register for counters 6..9.
- 0x14: overflow status.

Reads are combinational. Writes take effect at the clock edge.

Top module: `pmc_bank`

## Requirements
- R1: After reset, all counters read 0, overflow status is 0, the control and qualifier registers read 0, and `irq` is low.
- R2: Counter 0 increments on every enabled, qualified cycle. Counter 1 increments on each cycle with `inst_retired` high. Neither counter has a selector, and `evt_vec` has no effect on either.
- R3: Counter n in 2..5 uses the selector byte at bits [(n-2)*8+7:(n-2)*8] of register 0x12. Counter n in 6..9 uses bits [(n-6)*8+7:(n-6)*8] of register 0x13. Such a counter increments on a cycle where `evt_vec[selector]` is high.
- R4: Control bits [7:0] enable counters 0..7, and control bits [17:16] enable counters 8..9. A disabled counter holds its value.
- R5: Qualifier bits [7:0] and [17:16] allow counting in user mode (`priv_kernel`=0) for counters 0..7 and 8..9. Bits [15:8] and [19:18] allow counting in kernel mode (`priv_kernel`=1) for the same counters. A counter counts only when the bit for the current mode is set.
- R6: Counters are 48 bits wide and wrap to 0. An increment that takes bit 47 from 0 to 1 sets that counter's status bit. A wrap does not set it, and a software write does not set it.
- R7: Writing 1 to a bit of status register 0x14 (bits [9:0]) clears that bit, and writing 0 leaves the bit unchanged. A set and a clear in the same cycle leave the bit set.
- R8: A write to a counter takes priority over an increment in the same cycle. The written value appears after that edge.
- R9: `irq` is high exactly when the mode field, control bits [21:20], equals 1 and some counter has both its status bit and its interrupt enable set. Interrupt enables are control bits [15:8] for counters 0..7 and [19:18] for counters 8..9.
- R10: The interrupt-active flag, control bit 22 (read-only), is set on the edge after `irq` is high. It reads 0 right after any write to the control register, and that write takes priority over setting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_kernel | input | 1 | Current privilege: 1 kernel, 0 user |
| inst_retired | input | 1 | Instruction-retired pulse for counter 1 |
| evt_vec | input | 256 | Event pulse lines indexed by selector code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 48 | Register write data |
| reg_rdata | output | 48 | Register read data (combinational) |
| cnt_flat | output | 480 | All counter values, counter n at [n*48+47:n*48] |
| ovf_status | output | 10 | Overflow status, one bit per counter |
| irq | output | 1 | Overflow interrupt request |

## Verification
On every cycle, the assertions check four things:
- a counter holds when it is neither counting nor written;
- a counter write lands ahead of any increment;
- a status bit rises only on an increment across bit 47;
- the active flag is cleared by control writes and set by `irq`.

Only the directed scenarios can show the rest. These cover the mapping of packed selector bytes and split enable groups to counters, counting under the privilege qualifiers, the wrap at 48 bits, and set-beats-clear on the status register. They also show that `irq` is gated by the mode field and by the interrupt enables.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int NCNT    = 10;
  localparam int LO_GRP  = 8;
  localparam int HI_GRP  = NCNT - LO_GRP;
  localparam int EVT_W   = 8;
  localparam int ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] A_CTL  = 5'h10;
  localparam logic [ADDR_W-1:0] A_FLT  = 5'h11;
  localparam logic [ADDR_W-1:0] A_SELA = 5'h12;
  localparam logic [ADDR_W-1:0] A_SELB = 5'h13;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h14;

  localparam logic [1:0] MODE_FAST = 2'd1;

  // Join the two register groups into one per-counter vector.
  function automatic logic [NCNT-1:0] join_grp(logic [LO_GRP-1:0] lo, logic [HI_GRP-1:0] hi);
    return {hi, lo};
  endfunction

  // Event code for a selectable counter: four bytes per select register.
  function automatic logic [EVT_W-1:0] sel_code(logic [31:0] sel_a, logic [31:0] sel_b, int idx);
    if (idx < 6) return sel_a[(idx-2)*EVT_W +: EVT_W];
    else         return sel_b[(idx-6)*EVT_W +: EVT_W];
  endfunction
endpackage

// File: rtl/pmc_lane.sv
module pmc_lane #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_ok,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  logic         inc;
  logic         ovf_set;
  logic [W-1:0] nxt;

  assign inc     = count_ok & ~wr;
  assign nxt     = cnt + 1'b1;
  assign ovf_set = inc & ~cnt[W-1] & nxt[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr)       cnt <= wdata;
      else if (inc) cnt <= nxt;
      ovf <= ovf_set | (ovf & ~ovf_clr);
    end
  end

  // R8
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == $past(wdata));
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_ok && !wr) |=> $stable(cnt));
  // R6
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(inc) && !$past(cnt[W-1]) && cnt[W-1]));
endmodule

// File: rtl/pmc_irq.sv
module pmc_irq import pmc_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [NCNT-1:0] ovf,
  input  logic [NCNT-1:0] ie,
  input  logic            ctl_wr,
  output logic            irq,
  output logic            active
);
  assign irq = (mode == MODE_FAST) && |(ovf & ie);

  always_ff @(posedge clk) begin
    if (!rst_n)      active <= 1'b0;
    else if (ctl_wr) active <= 1'b0;
    else if (irq)    active <= 1'b1;
  end

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ovf));
  // R10
  act_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !active);
  // R10
  act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_wr) |=> active);
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank import pmc_pkg::*; #(
  parameter int CNT_W = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    priv_kernel,
  input  logic                    inst_retired,
  input  logic [(1<<EVT_W)-1:0]   evt_vec,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [CNT_W-1:0]        reg_wdata,
  output logic [CNT_W-1:0]        reg_rdata,
  output logic [NCNT*CNT_W-1:0]   cnt_flat,
  output logic [NCNT-1:0]         ovf_status,
  output logic                    irq
);
  logic [LO_GRP-1:0] en_lo, ie_lo, usr_lo, krn_lo;
  logic [HI_GRP-1:0] en_hi, ie_hi, usr_hi, krn_hi;
  logic [1:0]        mode;
  logic [31:0]       sel_a, sel_b;
  logic              active;

  logic [NCNT-1:0]   en_v, ie_v, usr_v, krn_v;
  logic [NCNT-1:0]   gate, cnt_wr, st_clr;
  logic [CNT_W-1:0]  cnt [NCNT];
  logic              ctl_wr;
  logic [22:0]       ctl_word;
  logic [19:0]       flt_word;

  assign en_v  = join_grp(en_lo, en_hi);
  assign ie_v  = join_grp(ie_lo, ie_hi);
  assign usr_v = join_grp(usr_lo, usr_hi);
  assign krn_v = join_grp(krn_lo, krn_hi);

  assign ctl_wr   = reg_we && (reg_addr == A_CTL);
  assign st_clr   = (reg_we && reg_addr == A_STAT) ? reg_wdata[NCNT-1:0] : '0;
  assign ctl_word = {active, mode, ie_hi, en_hi, ie_lo, en_lo};
  assign flt_word = {krn_hi, usr_hi, krn_lo, usr_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_lo <= '0; en_hi <= '0; ie_lo <= '0; ie_hi <= '0;
      usr_lo <= '0; usr_hi <= '0; krn_lo <= '0; krn_hi <= '0;
      mode <= '0; sel_a <= '0; sel_b <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTL: begin
          en_lo <= reg_wdata[7:0];
          ie_lo <= reg_wdata[15:8];
          en_hi <= reg_wdata[17:16];
          ie_hi <= reg_wdata[19:18];
          mode  <= reg_wdata[21:20];
        end
        A_FLT: begin
          usr_lo <= reg_wdata[7:0];
          krn_lo <= reg_wdata[15:8];
          usr_hi <= reg_wdata[17:16];
          krn_hi <= reg_wdata[19:18];
        end
        A_SELA: sel_a <= reg_wdata[31:0];
        A_SELB: sel_b <= reg_wdata[31:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_lane
    logic evt_hit;
    if (g == 0) begin : g_cyc
      assign evt_hit = 1'b1;
    end else if (g == 1) begin : g_ins
      assign evt_hit = inst_retired;
    end else begin : g_sel
      assign evt_hit = evt_vec[sel_code(sel_a, sel_b, g)];
    end
    assign gate[g]   = en_v[g] & (priv_kernel ? krn_v[g] : usr_v[g]) & evt_hit;
    assign cnt_wr[g] = reg_we && (reg_addr == ADDR_W'(g));

    pmc_lane #(.W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_ok (gate[g]),
      .wr       (cnt_wr[g]),
      .wdata    (reg_wdata),
      .ovf_clr  (st_clr[g]),
      .cnt      (cnt[g]),
      .ovf      (ovf_status[g])
    );
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt[g];
  end

  pmc_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .ovf    (ovf_status),
    .ie     (ie_v),
    .ctl_wr (ctl_wr),
    .irq    (irq),
    .active (active)
  );

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NCNT; k++)
      if (reg_addr == ADDR_W'(k)) reg_rdata = cnt[k];
    case (reg_addr)
      A_CTL:   reg_rdata = CNT_W'(ctl_word);
      A_FLT:   reg_rdata = CNT_W'(flt_word);
      A_SELA:  reg_rdata = CNT_W'(sel_a);
      A_SELB:  reg_rdata = CNT_W'(sel_b);
      A_STAT:  reg_rdata = CNT_W'(ovf_status);
      default: ;
    endcase
  end
endmodule

// File: tb/test_pmc_bank.sv
module test_pmc_bank;
  localparam int W = 48;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n, priv_kernel, inst_retired, reg_we;
  logic [255:0]   evt_vec;
  logic [4:0]     reg_addr;
  logic [W-1:0]   reg_wdata;
  wire  [W-1:0]   reg_rdata;
  wire  [10*W-1:0] cnt_flat;
  wire  [9:0]     ovf_status;
  wire            irq;

  int n_chk = 0;
  int n_bad = 0;

  pmc_bank i_pmc_bank (
    .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel), .inst_retired(inst_retired),
    .evt_vec(evt_vec), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_flat(cnt_flat), .ovf_status(ovf_status), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] cnt_of(input int i);
    return cnt_flat[i*W +: W];
  endfunction

  function automatic logic [W-1:0] ctl(input logic [9:0] en, input logic [9:0] ie, input logic [1:0] md);
    logic [W-1:0] w = '0;
    w[7:0] = en[7:0]; w[17:16] = en[9:8];
    w[15:8] = ie[7:0]; w[19:18] = ie[9:8];
    w[21:20] = md;
    return w;
  endfunction

  function automatic logic [W-1:0] flt(input logic [9:0] usr, input logic [9:0] krn);
    logic [W-1:0] w = '0;
    w[7:0] = usr[7:0]; w[17:16] = usr[9:8];
    w[15:8] = krn[7:0]; w[19:18] = krn[9:8];
    return w;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    for (int i = 0; i < 10; i++) check("R1 counter", cnt_of(i), '0);
    check("R1 status", W'(ovf_status), '0);
    check("R1 irq", W'(irq), '0);
    rd(5'h10, d); check("R1 control", d, '0);
    rd(5'h11, d); check("R1 qualifier", d, '0);
  endtask

  task automatic t_cycles();
    priv_kernel = 1'b1;
    wr(5'h11, flt(10'h001, 10'h000));
    wr(5'h10, ctl(10'h001, 10'h000, 2'd0));
    wr(5'h00, '0);
    priv_kernel = 1'b0;
    repeat (5) @(negedge clk);
    priv_kernel = 1'b1;
    check("R2 cycle counter", cnt_of(0), 48'd5);
    repeat (3) @(negedge clk);
    check("R5 kernel mode not qualified", cnt_of(0), 48'd5);
  endtask

  task automatic t_instr();
    wr(5'h11, flt(10'h000, 10'h002));
    wr(5'h10, ctl(10'h002, 10'h000, 2'd0));
    wr(5'h01, '0);
    evt_vec = '1;
    priv_kernel = 1'b1;
    for (int k = 0; k < 6; k++) begin
      inst_retired = k[0];
      @(negedge clk);
    end
    inst_retired = 1'b0;
    evt_vec = '0;
    check("R2 instruction counter", cnt_of(1), 48'd3);
    check("R5 counter 0 kernel disabled", cnt_of(0), 48'd5);
  endtask

  task automatic t_select();
    wr(5'h12, 48'h0000_0000_2133);
    wr(5'h13, 48'h0000_0040_0000);
    wr(5'h11, flt(10'h3FF, 10'h3FF));
    wr(5'h10, ctl(10'h108, 10'h000, 2'd0));
    evt_vec = '0; evt_vec[8'h21] = 1'b1; evt_vec[8'h33] = 1'b1;
    repeat (4) @(negedge clk);
    evt_vec = '0; evt_vec[8'h40] = 1'b1;
    repeat (2) @(negedge clk);
    evt_vec = '0; evt_vec[8'h55] = 1'b1;
    repeat (3) @(negedge clk);
    evt_vec = '0;
    check("R3 counter 3 byte 1 of select A", cnt_of(3), 48'd4);
    check("R3 counter 8 byte 2 of select B", cnt_of(8), 48'd2);
    check("R4 counter 2 disabled holds", cnt_of(2), 48'd0);
  endtask

  task automatic t_overflow();
    logic [W-1:0] d;
    wr(5'h13, 48'h0000_7A40_0000);
    wr(5'h09, 48'h7FFF_FFFF_FFFE);
    wr(5'h10, ctl(10'h200, 10'h200, 2'd0));
    evt_vec[8'h7A] = 1'b1;
    @(negedge clk);
    check("R6 below bit 47 no status", W'(ovf_status), '0);
    @(negedge clk);
    evt_vec = '0;
    check("R6 counter value", cnt_of(9), 48'h8000_0000_0000);
    check("R6 status set on bit 47", W'(ovf_status), 48'h200);
    check("R9 mode off no irq", W'(irq), '0);
    wr(5'h10, ctl(10'h200, 10'h200, 2'd1));
    check("R9 irq with fast mode", W'(irq), 48'd1);
    rd(5'h10, d); check("R10 active cleared by control write", W'(d[22]), '0);
    @(negedge clk);
    rd(5'h10, d); check("R10 active set after irq", W'(d[22]), 48'd1);
    wr(5'h10, ctl(10'h200, 10'h000, 2'd1));
    check("R9 irq gated by interrupt enable", W'(irq), '0);
    wr(5'h10, ctl(10'h200, 10'h200, 2'd2));
    check("R9 mode 2 no irq", W'(irq), '0);
    wr(5'h10, ctl(10'h200, 10'h200, 2'd1));
  endtask

  task automatic t_w1c();
    wr(5'h14, 48'h1FF);
    check("R7 write 0 keeps bit", W'(ovf_status), 48'h200);
    wr(5'h14, 48'h200);
    check("R7 write 1 clears bit", W'(ovf_status), '0);
    check("R9 irq drops after clear", W'(irq), '0);
    wr(5'h09, 48'h7FFF_FFFF_FFFF);
    @(negedge clk);
    evt_vec[8'h7A] = 1'b1;
    reg_we = 1'b1; reg_addr = 5'h14; reg_wdata = 48'h200;
    @(negedge clk);
    reg_we = 1'b0; evt_vec = '0;
    check("R7 set beats clear", W'(ovf_status), 48'h200);
    wr(5'h14, 48'h200);
  endtask

  task automatic t_write_prio();
    @(negedge clk);
    evt_vec[8'h7A] = 1'b1;
    reg_we = 1'b1; reg_addr = 5'h09; reg_wdata = 48'h8000_0000_0000;
    @(negedge clk);
    reg_we = 1'b0;
    check("R8 write beats increment", cnt_of(9), 48'h8000_0000_0000);
    check("R6 write sets no status", W'(ovf_status), '0);
    @(negedge clk);
    evt_vec = '0;
    check("R8 counting resumes", cnt_of(9), 48'h8000_0000_0001);
  endtask

  task automatic t_wrap();
    wr(5'h09, 48'hFFFF_FFFF_FFFF);
    evt_vec[8'h7A] = 1'b1;
    @(negedge clk);
    evt_vec = '0;
    check("R6 wraps to zero", cnt_of(9), '0);
    check("R6 wrap sets no status", W'(ovf_status), '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; priv_kernel = 1'b0; inst_retired = 1'b0; reg_we = 1'b0;
    evt_vec = '0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cycles();
    t_instr();
    t_select();
    t_overflow();
    t_w1c();
    t_write_prio();
    t_wrap();
    summary();
    $finish;
  end
endmodule